// File: doc/BRIEF.md
# Gray-Coded Delay Setting Offset Adjuster

This block sits between a delay-locked loop and a strobe delay chain. The loop reports the delay setting it has locked to as a Gray-coded word. The block converts that word to binary and applies a phase offset to it. It then clamps the result to the range the current frequency mode allows, converts it back to Gray code and registers it for the delay chain. A flag marks every result that had to be clamped.

The offset source is fixed at build time by a mode parameter. The first option is a static signed constant, where a positive value adds and a negative value subtracts. The other three use a six-bit unsigned offset input: it can always add, always subtract, or add or subtract under control of a direction select line. The `wide_mode` input picks between six-bit settings, with a ceiling of 63, and five-bit settings, with a ceiling of 31.

Top module: `dly_ofs_adjust`

## Requirements
- R1: `dly_gray_in` is read as reflected binary Gray code: binary bit i is the XOR of Gray bits i and above. `dly_gray_out` carries the adjusted value encoded as g = b XOR (b >> 1).
- R2: While `rst` is high at a rising clock edge, that edge sets `dly_gray_out` to 0 and `sat` to 0.
- R3: Inputs sampled at a rising edge affect the outputs from that same edge onward. Between edges the outputs do not change.
- R4: With `wide_mode` = 1, all six bits of the setting are used and the adjusted value is clamped to at most 63. For example, 28 + 35 gives 63 without clamping, and 28 + 36 gives 63 with clamping.
- R5: With `wide_mode` = 0, bit 5 of `dly_gray_in` is ignored, bit 5 of `dly_gray_out` is 0, and the value is clamped to at most 31. For example, 28 + 3 gives 31 without clamping, and 28 + 4 gives 31 with clamping.
- R6: A result below zero is clamped to 0. For example, 28 − 28 gives 0 without clamping, and 28 − 29 gives 0 with clamping.
- R7: With MODE = OFS_STATIC, the signed parameter STATIC_OFS is added to the base, and `dyn_ofs` and `add_sel` have no effect.
- R8: With MODE = OFS_ADD, the unsigned value of `dyn_ofs` is added to the base, and `add_sel` has no effect.
- R9: With MODE = OFS_SUB, the unsigned value of `dyn_ofs` is subtracted from the base, and `add_sel` has no effect.
- R10: With MODE = OFS_SEL, `add_sel` = 1 adds `dyn_ofs` and `add_sel` = 0 subtracts it.
- R11: `sat` is 1 exactly when the unclamped result fell outside the range from 0 to the ceiling of the current mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects six-bit settings (ceiling 63); 0 selects five-bit settings (ceiling 31) |
| dly_gray_in | input | 6 | Gray-coded delay setting from the delay-locked loop |
| dyn_ofs | input | 6 | Unsigned dynamic offset amount |
| add_sel | input | 1 | Direction in OFS_SEL mode: 1 adds, 0 subtracts |
| dly_gray_out | output | 6 | Registered, Gray-coded adjusted setting |
| sat | output | 1 | Registered flag: the result was clamped |

## Verification
The block holds state only in its output register. A wrong decode, a wrong offset direction or a wrong clamp therefore appears at `dly_gray_out` one edge after the input that caused it. The failure cannot hide longer than that single cycle. Errors are most likely at the limits: values just inside and just outside 0, 31 and 63, and a set bit 5 on the input in five-bit mode. There, a mis-decoded Gray code or a ceiling taken from the wrong mode changes either the output word or `sat` on the very next cycle. The reference model recomputes every output from the inputs on every cycle, so any mismatch is caught at the edge where it appears.

// File: rtl/dly_ofs_pkg.sv
package dly_ofs_pkg;

    localparam int SET_W      = 6;
    localparam int NARROW_W   = 5;
    localparam int SUM_W      = SET_W + 2;
    localparam int WIDE_MAX   = (1 << SET_W) - 1;
    localparam int NARROW_MAX = (1 << NARROW_W) - 1;

    typedef logic [SET_W-1:0]        setting_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    typedef enum logic [1:0] {
        OFS_STATIC = 2'd0,
        OFS_ADD    = 2'd1,
        OFS_SUB    = 2'd2,
        OFS_SEL    = 2'd3
    } ofs_mode_e;

    typedef struct packed {
        setting_t value;
        logic     sat;
    } adj_t;

    function automatic setting_t gray_to_bin(input setting_t g);
        setting_t b;
        b[SET_W-1] = g[SET_W-1];
        for (int i = SET_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic setting_t bin_to_gray(input setting_t b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/dly_ofs_decode.sv
module dly_ofs_decode
    import dly_ofs_pkg::*;
(
    input  logic     wide_mode,
    input  setting_t gray_in,
    output setting_t base_bin
);
    localparam int HIGH_BITS = SET_W - NARROW_W;

    setting_t masked;

    // In five-bit mode the upper bits are dropped before the decode.
    always_comb begin
        masked = gray_in;
        if (!wide_mode) begin
            masked[SET_W-1 -: HIGH_BITS] = '0;
        end
    end

    assign base_bin = gray_to_bin(masked);

endmodule

// File: rtl/dly_ofs_arith.sv
module dly_ofs_arith
    import dly_ofs_pkg::*;
#(
    parameter ofs_mode_e MODE       = OFS_SEL,
    parameter int        STATIC_OFS = 0
) (
    input  logic     wide_mode,
    input  setting_t base_bin,
    input  setting_t dyn_ofs,
    input  logic     add_sel,
    output adj_t     result
);
    localparam sum_t CEIL_WIDE   = sum_t'(WIDE_MAX);
    localparam sum_t CEIL_NARROW = sum_t'(NARROW_MAX);
    localparam sum_t STATIC_S    = sum_t'(STATIC_OFS);

    sum_t base_s;
    sum_t dyn_s;
    sum_t ofs_s;
    sum_t sum_s;
    sum_t ceil_s;

    assign base_s = sum_t'({2'b00, base_bin});
    assign dyn_s  = sum_t'({2'b00, dyn_ofs});
    assign ceil_s = wide_mode ? CEIL_WIDE : CEIL_NARROW;

    // The offset source and its sign are fixed by MODE at elaboration.
    generate
        if (MODE == OFS_STATIC) begin : g_static
            assign ofs_s = STATIC_S;
        end else if (MODE == OFS_ADD) begin : g_add
            assign ofs_s = dyn_s;
        end else if (MODE == OFS_SUB) begin : g_sub
            assign ofs_s = -dyn_s;
        end else begin : g_sel
            assign ofs_s = add_sel ? dyn_s : -dyn_s;
        end
    endgenerate

    assign sum_s = base_s + ofs_s;

    always_comb begin
        if (sum_s < 0) begin
            result.value = '0;
            result.sat   = 1'b1;
        end else if (sum_s > ceil_s) begin
            result.value = setting_t'(ceil_s);
            result.sat   = 1'b1;
        end else begin
            result.value = setting_t'(sum_s);
            result.sat   = 1'b0;
        end
    end

endmodule

// File: rtl/dly_ofs_adjust.sv
module dly_ofs_adjust
    import dly_ofs_pkg::*;
#(
    parameter ofs_mode_e MODE       = OFS_SEL,
    parameter int        STATIC_OFS = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wide_mode,
    input  logic [SET_W-1:0] dly_gray_in,
    input  logic [SET_W-1:0] dyn_ofs,
    input  logic             add_sel,
    output logic [SET_W-1:0] dly_gray_out,
    output logic             sat
);
    setting_t base_bin;
    adj_t     adj;
    setting_t out_bin;

    dly_ofs_decode u_decode (
        .wide_mode (wide_mode),
        .gray_in   (dly_gray_in),
        .base_bin  (base_bin)
    );

    dly_ofs_arith #(
        .MODE       (MODE),
        .STATIC_OFS (STATIC_OFS)
    ) u_arith (
        .wide_mode (wide_mode),
        .base_bin  (base_bin),
        .dyn_ofs   (dyn_ofs),
        .add_sel   (add_sel),
        .result    (adj)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_gray_out <= bin_to_gray('0);
            sat          <= 1'b0;
        end else begin
            dly_gray_out <= bin_to_gray(adj.value);
            sat          <= adj.sat;
        end
    end

    assign out_bin = gray_to_bin(dly_gray_out);

    // R2: a reset edge leaves a zero setting and a clear flag
    a_r2_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (dly_gray_out == '0 && !sat));

    // R5: five-bit mode never drives the top output bit
    a_r5_narrow_msb: assert property (@(posedge clk) disable iff (rst)
        !wide_mode |=> !dly_gray_out[SET_W-1]);

    // R11: a clamped result always sits on a limit
    a_r11_sat_on_limit: assert property (@(posedge clk) disable iff (rst)
        sat |-> (out_bin == '0 || out_bin == setting_t'(NARROW_MAX)
                 || out_bin == setting_t'(WIDE_MAX)));

    generate
        if (MODE == OFS_ADD) begin : g_chk_add
            // R8: adding never lowers the setting
            a_r8_not_below: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> out_bin >= $past(base_bin));
        end
        if (MODE == OFS_SUB) begin : g_chk_sub
            // R9: subtracting never raises the setting
            a_r9_not_above: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> out_bin <= $past(base_bin));
        end
    endgenerate

endmodule

// File: tb/dly_ofs_adjust_bench.sv
`timescale 1ns/1ps
module dly_ofs_adjust_bench;
    import dly_ofs_pkg::*;

    localparam int NI = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wide_mode = 1'b1;
    logic [5:0] dly_gray_in = '0;
    logic [5:0] dyn_ofs = '0;
    logic add_sel = 1'b0;

    logic [5:0] gout [NI];
    logic       sout [NI];

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    int exp_val [NI];
    bit exp_sat [NI];
    string exp_tag [NI];

    always #2 clk = ~clk;

    // instance 0: selectable direction; 1: add; 2: sub; 3: static +7; 4: static -5
    dly_ofs_adjust #(.MODE(OFS_SEL)) u_dly_ofs_adjust (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .dly_gray_in(dly_gray_in),
        .dyn_ofs(dyn_ofs), .add_sel(add_sel), .dly_gray_out(gout[0]), .sat(sout[0]));
    dly_ofs_adjust #(.MODE(OFS_ADD)) u_dly_ofs_adjust_add (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .dly_gray_in(dly_gray_in),
        .dyn_ofs(dyn_ofs), .add_sel(add_sel), .dly_gray_out(gout[1]), .sat(sout[1]));
    dly_ofs_adjust #(.MODE(OFS_SUB)) u_dly_ofs_adjust_sub (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .dly_gray_in(dly_gray_in),
        .dyn_ofs(dyn_ofs), .add_sel(add_sel), .dly_gray_out(gout[2]), .sat(sout[2]));
    dly_ofs_adjust #(.MODE(OFS_STATIC), .STATIC_OFS(7)) u_dly_ofs_adjust_sp (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .dly_gray_in(dly_gray_in),
        .dyn_ofs(dyn_ofs), .add_sel(add_sel), .dly_gray_out(gout[3]), .sat(sout[3]));
    dly_ofs_adjust #(.MODE(OFS_STATIC), .STATIC_OFS(-5)) u_dly_ofs_adjust_sn (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .dly_gray_in(dly_gray_in),
        .dyn_ofs(dyn_ofs), .add_sel(add_sel), .dly_gray_out(gout[4]), .sat(sout[4]));

    function automatic int to_gray(int b);
        return b ^ (b >> 1);
    endfunction

    // R1: decode by walking down from the top bit
    function automatic int from_gray(int g);
        int b = 0;
        int acc = 0;
        for (int i = 5; i >= 0; i--) begin
            acc = acc ^ ((g >> i) & 1);
            b = b | (acc << i);
        end
        return b;
    endfunction

    function automatic void model(int k, bit w, int gin, int dyn, bit sel,
                                  output int val, output bit s, output string tag);
        int base = from_gray(w ? gin : (gin & 31));
        int ceil = w ? 63 : 31;
        int sum;
        case (k)
            0: sum = sel ? base + dyn : base - dyn;
            1: sum = base + dyn;
            2: sum = base - dyn;
            3: sum = base + 7;
            default: sum = base - 5;
        endcase
        s = 1'b0;
        if (sum < 0) begin val = 0; s = 1'b1; tag = "R6 R11"; end
        else if (sum > ceil) begin val = ceil; s = 1'b1; tag = w ? "R4 R11" : "R5 R11"; end
        else begin
            val = sum;
            case (k)
                0: tag = "R1 R10";
                1: tag = "R1 R8";
                2: tag = "R1 R9";
                default: tag = "R1 R7";
            endcase
            if (!w) tag = {tag, " R5"};
        end
    endfunction

    task automatic check_outputs();
        if (!chk_en) return;
        for (int k = 0; k < NI; k++) begin
            checks++;
            if (gout[k] !== 6'(to_gray(exp_val[k]))) begin
                errors++;
                $display("FAIL %s inst%0d out: actual %0h expected %0h",
                         exp_tag[k], k, gout[k], to_gray(exp_val[k]));
            end
            checks++;
            if (sout[k] !== exp_sat[k]) begin
                errors++;
                $display("FAIL R11 (%s) inst%0d sat: actual %0b expected %0b",
                         exp_tag[k], k, sout[k], exp_sat[k]);
            end
        end
    endtask

    task automatic step(bit r, bit w, int base, int dyn, bit sel, bit msb_junk);
        int gin;
        @(negedge clk);
        check_outputs();
        gin = to_gray(base) | (msb_junk ? 32 : 0);
        rst = r; wide_mode = w; dly_gray_in = 6'(gin);
        dyn_ofs = 6'(dyn); add_sel = sel;
        // R3: new inputs must not reach the outputs before the next edge
        #0.5;
        if (chk_en) begin
            checks++;
            if (gout[0] !== 6'(to_gray(exp_val[0]))) begin
                errors++;
                $display("FAIL R3 early change: actual %0h expected %0h",
                         gout[0], to_gray(exp_val[0]));
            end
        end
        for (int k = 0; k < NI; k++) begin
            if (r) begin exp_val[k] = 0; exp_sat[k] = 1'b0; exp_tag[k] = "R2"; end
            else model(k, w, gin, dyn, sel, exp_val[k], exp_sat[k], exp_tag[k]);
        end
    endtask

    initial begin
        for (int k = 0; k < NI; k++) begin
            exp_val[k] = 0; exp_sat[k] = 1'b0; exp_tag[k] = "R2";
        end
        step(1, 1, 40, 9, 1, 0);
        step(1, 1, 40, 9, 1, 0);
        chk_en = 1'b1;
        step(1, 1, 12, 3, 1, 0);          // R2 reset holds zero
        step(0, 1, 28, 35, 1, 0);         // R4 reaches 63 exactly
        step(0, 1, 28, 36, 1, 0);         // R4 clamps at 63
        step(0, 0, 28, 3, 1, 0);          // R5 reaches 31 exactly
        step(0, 0, 28, 4, 1, 0);          // R5 clamps at 31
        step(0, 0, 28, 3, 1, 1);          // R5 top input bit ignored
        step(0, 1, 28, 28, 0, 0);         // R6 reaches 0 exactly
        step(0, 1, 28, 29, 0, 0);         // R6 clamps at 0
        step(0, 1, 60, 0, 0, 0);          // R7 static +7 clamps
        step(0, 1, 3, 0, 1, 0);           // R7 static -5 clamps
        step(0, 1, 20, 10, 0, 0);         // R8 R9 R10 add_sel ignored except sel
        step(0, 1, 20, 10, 1, 0);
        step(1, 1, 50, 5, 1, 0);          // R2 reset mid-run
        for (int n = 0; n < 400; n++) begin
            step(0, bit'($urandom_range(0, 1)), int'($urandom_range(0, 63)),
                 int'($urandom_range(0, 63)), bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 1)));
        end
        step(0, 1, 0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule